// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block holds a set of MAC event counters and makes them readable through a 16-bit register port. Counters for octet totals and for frame and error events sit side by side. The receive and transmit paths drive the increment inputs: a multi-bit octet amount for each wide counter and a single strobe for each event counter. The bank contains no frame parsing logic. The host does not read the counters directly. It first writes a snapshot command, which copies every live counter into a holding register in one cycle. It then reads the frozen copies at its own pace, and every value it reads belongs to the same instant.

Each counter is 40 bits and is read in three slices. A per-counter wrap flag records that the counter has passed through zero since the host last read the flags. Reading a flag register clears the flags in it, so a driver that polls slowly can extend the count in software. A second command bit zeroes all live counters at once.

The default build has four octet counters: receive octets, transmit octets, receive jumbo octets and transmit jumbo octets. It has eight event counters: receive frames, transmit frames, receive pause, transmit pause, receive FCS error, transmit FCS error, receive jumbo frames and transmit jumbo frames. Counter numbers follow that order, octet counters first.

Top module: `stat_snap_bank`

## Requirements
- R1: Counter k is read at address 4k (bits 15:0), 4k+1 (bits 31:16) and 4k+2 (bits 39:32 in data bits 7:0, with bits 15:8 zero). Address 4k+3 reads zero. The counter width is CNT_W (default 40). Bits at or above CNT_W read zero.
- R2: For k below NUM_WIDE, counter k adds the 5-bit field octetInc[5k+4:5k] (0 to 16) every cycle. For the other counters, counter k adds one when eventHit[k-NUM_WIDE] is high.
- R3: A write to the command address 0xF0 with data bit 0 set copies every live counter, as it stood before that clock edge, into its snapshot register. Counter reads return the snapshot, never the live value.
- R4: A write to 0xF0 with data bit 1 set zeroes every live counter at that edge. Increments in the same cycle are discarded, and the snapshots and wrap flags are left unchanged. The command bits act for one cycle only, and 0xF0 reads zero.
- R5: Wrap flag k sets when an increment carries out of the top bit of counter k. The flag sits at address 0xF4 + k/16, bit k%16. Flag positions with no counter read zero.
- R6: A read of a wrap-flag register returns its flags and clears them. A flag whose counter carries out in that same cycle stays set.
- R7: regRdData is registered. It shows the value addressed in the cycle that regRdEn was high, from the following clock edge, and it holds that value while regRdEn is low.
- R8: Any address that is not a counter slice or a wrap-flag register reads zero.
- R9: Reset clears all counters, snapshots, wrap flags and regRdData.
- R10: When snapshot and clear are written together, the snapshot receives the values from before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| octetInc | input | NUM_WIDE*INC_W | Per-cycle amount for each octet counter, 5 bits each by default |
| eventHit | input | NUM_NARROW | One strobe per event counter |
| regAddr | input | ADDR_W | Register address shared by reads and writes |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data (command bits 1:0) |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 16 | Registered read data |

## Verification
The bench targets four areas. The first is the edge at which snapshot, clear and increments meet: a design that snapped after the clear, or that let an increment through a clear, would return non-zero or post-clear values. The second is a wrap that coincides with a read of its flag register, where a design that gives the clear priority loses the wrap event. The third is a narrow second instance that wraps within a few hundred cycles, which exposes wrong flag placement and wrong slice positions. The fourth is a stream of random reads over the unused fourth slot, the address gap and the flag registers, which shows whether reads of the live values or reads of stale data leak out.

// File: rtl/stat_snap_bank_pkg.sv
package stat_snap_bank_pkg;
  localparam int SLICE_TOTAL = 40;
  localparam int FLAG_W      = 16;
  localparam int FLAG_REGS   = 4;
  localparam int MAX_CNT     = FLAG_W * FLAG_REGS;
  localparam int IDX_W       = $clog2(MAX_CNT);

  typedef enum logic [1:0] {
    SL_LOW = 2'd0,
    SL_MID = 2'd1,
    SL_TOP = 2'd2,
    SL_GAP = 2'd3
  } slice_e;

  // strobes from the decoder to the datapath, valid for one cycle
  typedef struct packed {
    logic             snap;
    logic             clear;
    logic             rdAny;
    logic             rdCnt;
    logic             rdRoll;
    logic [IDX_W-1:0] cntIdx;
    slice_e           slice;
    logic [1:0]       rollIdx;
  } ctrl_t;
endpackage

// File: rtl/stat_snap_ctrl.sv
module stat_snap_ctrl
  import stat_snap_bank_pkg::*;
#(
  parameter int NUM_CNT = 12,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hF0,
  parameter logic [ADDR_W-1:0] ROLL_BASE = 8'hF4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  input  logic              regRdEn,
  output ctrl_t             ctrlS
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic [1:0]        wordSlot;
  logic [ADDR_W-1:0] rollOff;
  logic              inCnt;
  logic              inRoll;
  logic              isCmd;
  logic              unusedBits;

  assign wordIdx  = regAddr[ADDR_W-1:2];
  assign wordSlot = regAddr[1:0];
  assign rollOff  = regAddr - ROLL_BASE;
  assign inCnt    = ({2'b00, wordIdx} < ADDR_W'(NUM_CNT)) && (wordSlot != 2'b11);
  assign inRoll   = rollOff < ADDR_W'(FLAG_REGS);
  assign isCmd    = regAddr == CTRL_ADDR;
  assign unusedBits = ^regWrData[15:2];

  always_comb begin
    ctrlS         = '0;
    ctrlS.snap    = regWrEn && isCmd && regWrData[0];
    ctrlS.clear   = regWrEn && isCmd && regWrData[1];
    ctrlS.rdAny   = regRdEn;
    ctrlS.rdCnt   = regRdEn && inCnt;
    ctrlS.rdRoll  = regRdEn && inRoll;
    ctrlS.cntIdx  = IDX_W'(wordIdx);
    ctrlS.slice   = slice_e'(wordSlot);
    ctrlS.rollIdx = rollOff[1:0];
  end
endmodule

// File: rtl/stat_snap_dp.sv
module stat_snap_dp
  import stat_snap_bank_pkg::*;
#(
  parameter int NUM_WIDE   = 4,
  parameter int NUM_NARROW = 8,
  parameter int CNT_W      = 40,
  parameter int INC_W      = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_WIDE*INC_W-1:0] octetInc,
  input  logic [NUM_NARROW-1:0]     eventHit,
  input  ctrl_t                     ctrlS,
  output logic [15:0]               regRdData
);
  localparam int NUM_CNT = NUM_WIDE + NUM_NARROW;

  logic [CNT_W-1:0]       snapArr [NUM_CNT];
  logic [NUM_CNT-1:0]     rollVec;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    localparam int GRP = k / FLAG_W;
    logic [CNT_W-1:0] incK;
    logic [CNT_W:0]   sumK;
    logic [CNT_W-1:0] liveQ;
    logic [CNT_W-1:0] snapQ;
    logic             flagQ;
    logic             carryK;
    logic             rdHitK;

    if (k < NUM_WIDE) begin : g_wide
      assign incK = CNT_W'(octetInc[k*INC_W +: INC_W]);
    end else begin : g_narrow
      assign incK = CNT_W'(eventHit[k-NUM_WIDE]);
    end

    assign sumK   = {1'b0, liveQ} + {1'b0, incK};
    assign carryK = sumK[CNT_W] && !ctrlS.clear;
    assign rdHitK = ctrlS.rdRoll && (ctrlS.rollIdx == 2'(GRP));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveQ <= '0;
        snapQ <= '0;
        flagQ <= 1'b0;
      end else begin
        liveQ <= ctrlS.clear ? '0 : sumK[CNT_W-1:0];
        if (ctrlS.snap) snapQ <= liveQ;
        flagQ <= carryK || (flagQ && !rdHitK);
      end
    end

    assign snapArr[k] = snapQ;
    assign rollVec[k] = flagQ;
  end

  logic [CNT_W-1:0]       selSnap;
  logic [SLICE_TOTAL-1:0] wideSnap;
  logic [FLAG_W-1:0]      flagWord;
  logic [15:0]            rdVal;

  always_comb begin
    selSnap = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (ctrlS.cntIdx == IDX_W'(k)) selSnap = snapArr[k];
    end
    wideSnap = SLICE_TOTAL'(selSnap);
    flagWord = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (ctrlS.rollIdx == 2'(k / FLAG_W)) flagWord[k % FLAG_W] = rollVec[k];
    end
    rdVal = '0;
    if (ctrlS.rdCnt) begin
      case (ctrlS.slice)
        SL_LOW:  rdVal = wideSnap[15:0];
        SL_MID:  rdVal = wideSnap[31:16];
        SL_TOP:  rdVal = {8'h00, wideSnap[39:32]};
        default: rdVal = '0;
      endcase
    end else if (ctrlS.rdRoll) begin
      rdVal = flagWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) regRdData <= '0;
    else if (ctrlS.rdAny) regRdData <= rdVal;
  end
endmodule

// File: rtl/stat_snap_bank.sv
module stat_snap_bank
  import stat_snap_bank_pkg::*;
#(
  parameter int NUM_WIDE   = 4,
  parameter int NUM_NARROW = 8,
  parameter int CNT_W      = 40,
  parameter int MAX_INC    = 16,
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hF0,
  parameter logic [ADDR_W-1:0] ROLL_BASE = 8'hF4,
  localparam int INC_W = $clog2(MAX_INC + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_WIDE*INC_W-1:0] octetInc,
  input  logic [NUM_NARROW-1:0]     eventHit,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic                      regWrEn,
  input  logic [15:0]               regWrData,
  input  logic                      regRdEn,
  output logic [15:0]               regRdData
);
  localparam int NUM_CNT = NUM_WIDE + NUM_NARROW;

  ctrl_t ctrlS;

  stat_snap_ctrl #(
    .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .ROLL_BASE(ROLL_BASE)
  ) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .ctrlS(ctrlS)
  );

  stat_snap_dp #(
    .NUM_WIDE(NUM_WIDE), .NUM_NARROW(NUM_NARROW),
    .CNT_W(CNT_W), .INC_W(INC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .octetInc(octetInc), .eventHit(eventHit),
    .ctrlS(ctrlS), .regRdData(regRdData)
  );
endmodule

// File: rtl/stat_snap_bank_chk.sv
module stat_snap_bank_chk #(
  parameter int NUM_WIDE   = 4,
  parameter int NUM_NARROW = 8,
  parameter int MAX_INC    = 16,
  parameter int ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hF0,
  parameter logic [ADDR_W-1:0] ROLL_BASE = 8'hF4,
  parameter int INC_W      = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_WIDE*INC_W-1:0] octetInc,
  input logic [ADDR_W-1:0]         regAddr,
  input logic                      regWrEn,
  input logic                      regRdEn,
  input logic [15:0]               regRdData,
  input logic                      cmdSnap,
  input logic                      cmdClear,
  input logic                      selCnt,
  input logic                      selRoll
);
  localparam int NUM_CNT = NUM_WIDE + NUM_NARROW;

  logic [ADDR_W-1:0] rollOff;
  logic              inRollRange;
  logic              inCntRange;
  logic              overInc;

  assign rollOff     = regAddr - ROLL_BASE;
  assign inRollRange = rollOff < ADDR_W'(4);
  assign inCntRange  = regAddr < ADDR_W'(4 * NUM_CNT);

  always_comb begin
    overInc = 1'b0;
    for (int k = 0; k < NUM_WIDE; k++) begin
      if (int'(octetInc[k*INC_W +: INC_W]) > MAX_INC) overInc = 1'b1;
    end
  end

  function automatic logic [15:0] flagMask(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] j;
    flagMask = '0;
    j = a - ROLL_BASE;
    for (int b = 0; b < 16; b++) begin
      if (int'(j) * 16 + b < NUM_CNT) flagMask[b] = 1'b1;
    end
  endfunction

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData)); // R7
  AST_GAP_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && inCntRange && regAddr[1:0] == 2'b11) |=> regRdData == 16'h0); // R1
  AST_TOP_SLICE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && inCntRange && regAddr[1:0] == 2'b10) |=> regRdData[15:8] == 8'h00); // R1
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == CTRL_ADDR) |=> regRdData == 16'h0); // R4
  AST_CMD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> !(cmdSnap || cmdClear)); // R4
  AST_FLAG_GAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && inRollRange) |=> (regRdData & ~flagMask($past(regAddr))) == 16'h0); // R5
  AST_READ_KIND_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selCnt, selRoll})); // R8
  AST_INC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    !overInc); // R2
endmodule

bind stat_snap_bank stat_snap_bank_chk #(
  .NUM_WIDE(NUM_WIDE), .NUM_NARROW(NUM_NARROW), .MAX_INC(MAX_INC),
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .ROLL_BASE(ROLL_BASE), .INC_W(INC_W)
) u_chk (
  .clk(clk), .rstN(rstN), .octetInc(octetInc), .regAddr(regAddr),
  .regWrEn(regWrEn), .regRdEn(regRdEn), .regRdData(regRdData),
  .cmdSnap(ctrlS.snap), .cmdClear(ctrlS.clear),
  .selCnt(ctrlS.rdCnt), .selRoll(ctrlS.rdRoll)
);

// File: tb/test_stat_snap_bank.sv
`timescale 1ns/1ps
module test_stat_snap_bank;
  localparam int NW = 4;
  localparam int NN = 8;
  localparam int NC = NW + NN;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NW*5-1:0] octetInc = '0;
  logic [NN-1:0]   eventHit = '0;
  logic [7:0]      regAddr = '0;
  logic            regWrEn = 1'b0;
  logic [15:0]     regWrData = '0;
  logic            regRdEn = 1'b0;
  logic [15:0]     rdA, rdB;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stat_snap_bank i_stat_snap_bank (
    .clk(clk), .rstN(rstN), .octetInc(octetInc), .eventHit(eventHit),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(rdA));

  stat_snap_bank #(.CNT_W(10)) i_stat_snap_bank_wrap (
    .clk(clk), .rstN(rstN), .octetInc(octetInc), .eventHit(eventHit),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(rdB));

  // reference state per instance: 0 = 40-bit, 1 = 10-bit
  bit [63:0]   mLive [2][NC];
  bit [63:0]   mSnap [2][NC];
  bit          mRoll [2][NC];
  logic [15:0] mLast [2];
  int          mW [2] = '{40, 10};

  function automatic logic [15:0] expRead(int i, logic [7:0] ad);
    int k = int'(ad) / 4;
    int s = int'(ad) % 4;
    logic [15:0] r = '0;
    if (k < NC && s < 3) begin
      case (s)
        0: r = mSnap[i][k][15:0];
        1: r = mSnap[i][k][31:16];
        default: r = {8'h00, mSnap[i][k][39:32]};
      endcase
    end else if (ad >= 8'hF4 && ad <= 8'hF7) begin
      for (int kk = 0; kk < NC; kk++)
        if (kk / 16 == int'(ad) - 'hF4) r[kk % 16] = mRoll[i][kk];
    end
    return r;
  endfunction

  function automatic string tagOf(logic [7:0] ad);
    if (int'(ad) < 4 * NC && ad[1:0] != 2'b11) return "R1";
    if (ad >= 8'hF4 && ad <= 8'hF7) return "R5";
    return "R8";
  endfunction

  task automatic chk(string tag, int i, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s inst %0d: actual %h expected %h", tag, i, got, exp);
    end
  endtask

  // one cycle, entered and left at a falling edge
  task automatic cyc(logic [NW*5-1:0] oct, logic [NN-1:0] ev, logic wr,
                     logic [15:0] wd, logic rd, logic [7:0] ad, string tag);
    logic [15:0] exp [2];
    bit snapC, clrC;
    octetInc = oct; eventHit = ev; regWrEn = wr; regWrData = wd;
    regRdEn = rd; regAddr = ad;
    snapC = wr && ad == 8'hF0 && wd[0];
    clrC  = wr && ad == 8'hF0 && wd[1];
    for (int i = 0; i < 2; i++) begin
      bit [63:0] mask = (64'd1 << mW[i]) - 64'd1;
      exp[i] = rd ? expRead(i, ad) : mLast[i];
      for (int k = 0; k < NC; k++) begin
        bit [63:0] inc = (k < NW) ? 64'(oct[k*5 +: 5]) : 64'(ev[k-NW]);
        bit [63:0] sum = mLive[i][k] + inc;
        bit carry = sum > mask;
        bit rdClr = rd && (ad == 8'hF4 + 8'(k / 16));
        mRoll[i][k] = (carry && !clrC) || (mRoll[i][k] && !rdClr);
        if (snapC) mSnap[i][k] = mLive[i][k];
        mLive[i][k] = clrC ? 64'd0 : (sum & mask);
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(rd ? ((tag == "") ? tagOf(ad) : tag) : "R7", i, (i == 0) ? rdA : rdB, exp[i]);
      mLast[i] = exp[i];
    end
  endtask

  task automatic rdAll(string tag);
    for (int k = 0; k < NC; k++)
      for (int s = 0; s < 3; s++) cyc('0, '0, 0, 0, 1, 8'(4 * k + s), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 2; i++) begin
      mLast[i] = '0;
      for (int k = 0; k < NC; k++) begin mLive[i][k] = 0; mSnap[i][k] = 0; mRoll[i][k] = 0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R9", 0, rdA, 16'h0);
    chk("R9", 1, rdB, 16'h0);
    cyc('0, '0, 0, 0, 1, 8'h00, "R9");
    cyc('0, '0, 0, 0, 1, 8'hF4, "R9");

    // R2: distinct octet amounts and event strobes
    for (int n = 0; n < 5; n++) cyc({5'd16, 5'd3, 5'd0, 5'd9}, 8'b1010_0110, 0, 0, 0, 0, "");
    cyc({5'd1, 5'd1, 5'd1, 5'd1}, 8'hFF, 0, 0, 0, 0, "");
    cyc('0, '0, 1, 16'h0001, 0, 8'hF0, "");
    rdAll("R2");

    // R3: snapshot frozen while live counters move
    for (int n = 0; n < 4; n++) cyc({4{5'd16}}, 8'hFF, 0, 0, 0, 0, "");
    cyc({4{5'd7}}, 8'hFF, 0, 0, 1, 8'h00, "R3");
    cyc({4{5'd7}}, 8'hFF, 1, 16'h0001, 0, 8'hF0, "");
    cyc('0, '0, 0, 0, 1, 8'h00, "R3");
    cyc('0, '0, 0, 0, 1, 8'h10, "R3");

    // R10 and R4: snap with clear, increments discarded
    cyc({4{5'd16}}, 8'hFF, 1, 16'h0003, 0, 8'hF0, "");
    rdAll("R10");
    cyc('0, '0, 1, 16'h0000, 1, 8'hF0, "R4");
    cyc('0, '0, 1, 16'h0001, 0, 8'hF0, "");
    rdAll("R4");

    // R5: octet wrap on the narrow instance
    cyc('0, '0, 1, 16'h0002, 0, 8'hF0, "");
    cyc('0, '0, 0, 0, 1, 8'hF4, "R6");
    for (int n = 0; n < 64; n++) cyc({5'd0, 5'd0, 5'd0, 5'd16}, '0, 0, 0, 0, 0, "");
    cyc('0, '0, 0, 0, 1, 8'hF4, "R5");
    cyc('0, '0, 0, 0, 1, 8'hF5, "R5");

    // R6: wrap in the same cycle as the flag read
    cyc('0, '0, 1, 16'h0002, 0, 8'hF0, "");
    cyc('0, '0, 0, 0, 1, 8'hF4, "R6");
    for (int n = 0; n < 1023; n++) cyc('0, 8'h01, 0, 0, 0, 0, "");
    cyc('0, 8'h01, 0, 0, 1, 8'hF4, "R6");
    cyc('0, '0, 0, 0, 1, 8'hF4, "R6");
    cyc('0, '0, 0, 0, 1, 8'hF4, "R6");

    // R8: unmapped holes
    cyc('0, '0, 0, 0, 1, 8'h03, "R8");
    cyc('0, '0, 0, 0, 1, 8'h30, "R8");
    cyc('0, '0, 0, 0, 1, 8'hF1, "R8");
    cyc('0, '0, 0, 0, 1, 8'hF8, "R8");
    cyc('0, '0, 0, 0, 1, 8'hFF, "R8");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [NW*5-1:0] oct;
      logic wr, rd;
      logic [15:0] wd;
      logic [7:0] ad;
      int pick;
      for (int k = 0; k < NW; k++) oct[k*5 +: 5] = 5'($urandom_range(16));
      wr = ($urandom % 10) == 0;
      wd = {14'h0, ($urandom % 8) == 0, 1'($urandom)};
      rd = ($urandom % 3) != 0;
      pick = int'($urandom % 100);
      if (wr) ad = 8'hF0;
      else if (pick < 70) ad = 8'($urandom % 64);
      else if (pick < 85) ad = 8'hF4 + 8'($urandom % 4);
      else ad = 8'($urandom);
      cyc(oct, 8'($urandom), wr, wd, rd, ad, "");
    end
    cyc('0, '0, 1, 16'h0001, 0, 8'hF0, "");
    rdAll("R3");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule